// File: doc/BRIEF.md
# Serial Target Front End with Clock-Mode Auto-Detection

This block is the receive/transmit front end of a serial peripheral target. A bus master selects it by pulling the active-low select line, then clocks bytes in on the data-in line. At the same time it clocks bytes out on the data-out line. The master may use either clocking mode 0 (clock idles low) or mode 3 (clock idles high). The block is not told which one. It reads the clock level at the moment of selection and picks the mode from it. It repeats this on every selection.

All serial inputs are oversampled by a faster system clock through synchronizer chains. Edges are found from the synchronized clock history. Each completed byte is handed to the parallel side with a one-cycle valid strobe. The bit counter wraps, so a master can stream any number of bytes within one selection. The next outgoing byte is written into a one-entry holding register through a ready/load handshake. The holding register is drained at the start of every outgoing byte.

Top module: `spi_autodet_target`

## Requirements
- R1: The mode is taken from the synchronized SCK level in the cycle the select is seen falling: low selects mode 0 and high selects mode 3. It is held for the whole selection and taken again at the next selection.
- R2: SI is captured only on rising SCK edges while selected. Bits are assembled most significant first: the first capture edge gives bit 7 and the eighth gives bit 0.
- R3: In mode 3 the high SCK level present at selection is never a capture edge. Capture starts with the first rising edge that follows a falling edge.
- R4: After the eighth capture edge, rx_data holds the byte and rx_valid is high for exactly one cycle. The next capture edge starts a new byte within the same selection.
- R5: SO moves only after a falling SCK edge, or at selection in mode 0. Each outgoing byte is sent most significant bit first.
- R6: so_oe is low whenever the select is high. In mode 0 it rises at selection. In mode 3 it rises at the first falling SCK edge.
- R7: Raising the select discards a partial byte with no rx_valid. The next selection starts again at bit 7.
- R8: tx_ready is high while the holding register is empty. tx_load with tx_ready high stores tx_data and drops tx_ready. The held byte is moved out at the start of each outgoing byte.
- R9: An outgoing byte that starts while the holding register is empty is sent as all ones (0xFF).
- R10: After reset, rx_valid and so_oe are low and tx_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master (0 when not enabled) |
| so_oe | output | 1 | Output enable for the so pad driver |
| rx_data | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_data |
| tx_data | input | DATA_W | Next byte to transmit |
| tx_load | input | 1 | Write strobe for tx_data |
| tx_ready | output | 1 | Holding register empty |

## Verification
The bench builds the block with its defaults: an 8-bit data width and two synchronizer stages. With these values a byte boundary falls every eight edges, so the counter wrap between back-to-back bytes is reached within a few hundred cycles. The three-cycle path from SCK to SO also fits comfortably inside an eight-cycle SCK half period. At that rate the master can check every outgoing bit just before each rising edge, in both modes. This includes a mode 3 selection where SCK is already high, a selection aborted partway through a byte, and a transmit underrun.

// File: rtl/spi_autodet_pkg.sv
package spi_autodet_pkg;

  typedef enum logic {
    IDLE_LOW  = 1'b0,
    IDLE_HIGH = 1'b1
  } idle_lvl_e;

  function automatic logic is_rise(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RESET_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_tracker.sv
module spi_edge_tracker
  import spi_autodet_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n_s,
  input  logic      sck_s,
  output logic      active,
  output logic      sel_start,
  output logic      sel_low,
  output logic      cap_edge,
  output logic      drv_edge,
  output idle_lvl_e mode,
  output logic      armed
);
  logic cs_q, sck_q;
  logic rise_raw, fall_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_n_s;
      sck_q <= sck_s;
    end

  assign active    = ~cs_n_s;
  assign sel_start = is_fall(cs_q, cs_n_s);
  assign sel_low   = sel_start & ~sck_s;
  assign rise_raw  = is_rise(sck_q, sck_s);
  assign fall_raw  = is_fall(sck_q, sck_s);

  // mode latched at selection, cleared on deselect
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          mode <= IDLE_LOW;
    else if (!active)    mode <= IDLE_LOW;
    else if (sel_start)  mode <= sck_s ? IDLE_HIGH : IDLE_LOW;

  // capture is armed at once in mode 0, after the first fall in mode 3
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              armed <= 1'b0;
    else if (!active)        armed <= 1'b0;
    else if (sel_start)      armed <= ~sck_s;
    else if (fall_raw || mode == IDLE_LOW) armed <= 1'b1;

  assign cap_edge = active & ~sel_start & armed & rise_raw;
  assign drv_edge = active & ~sel_start & fall_raw;
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
  parameter int DATA_W = 8,
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cap_edge,
  input  logic              si_s,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              cnt_zero
);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     cnt;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v, input logic b);
    return {v[DATA_W-2:0], b};
  endfunction

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!active) begin
        cnt <= '0;
      end else if (cap_edge) begin
        sh  <= shift_in(sh, si_s);
        cnt <= next_cnt(cnt);
        if (cnt == LAST) begin
          rx_data  <= shift_in(sh, si_s);
          rx_valid <= 1'b1;
        end
      end
    end

  assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sel_low,
  input  logic              drv_edge,
  input  logic              cnt_zero,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic              load_evt,
  output logic              so,
  output logic              so_oe
);
  logic [DATA_W-1:0] hold, tx_sh;
  logic              full, live;
  logic              shift_evt, accept;

  function automatic logic [DATA_W-1:0] shift_out(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b1};
  endfunction

  assign load_evt  = sel_low | (drv_edge & cnt_zero);
  assign shift_evt = drv_edge & ~cnt_zero;
  assign tx_ready  = ~full;
  assign accept    = tx_load & ~full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
    end else begin
      if (accept) begin
        hold <= tx_data;
        full <= 1'b1;
      end else if (load_evt) begin
        full <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '1;
      live  <= 1'b0;
    end else if (!active) begin
      live  <= 1'b0;
    end else if (load_evt) begin
      tx_sh <= full ? hold : '1;
      live  <= 1'b1;
    end else if (shift_evt) begin
      tx_sh <= shift_out(tx_sh);
    end

  assign so_oe = live & active;
  assign so    = so_oe & tx_sh[DATA_W-1];
endmodule

// File: rtl/spi_autodet_target.sv
module spi_autodet_target
  import spi_autodet_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready
);
  logic      cs_n_s, sck_s, si_s;
  logic      active, sel_start, sel_low, cap_edge, drv_edge, armed;
  logic      cnt_zero, load_evt;
  idle_lvl_e mode;

  spi_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_n_s));
  spi_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));
  spi_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_si (
    .clk(clk), .rst_n(rst_n), .d(si), .q(si_s));

  spi_edge_tracker u_edges (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s),
    .active(active), .sel_start(sel_start), .sel_low(sel_low),
    .cap_edge(cap_edge), .drv_edge(drv_edge), .mode(mode), .armed(armed));

  spi_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(active), .cap_edge(cap_edge),
    .si_s(si_s), .rx_data(rx_data), .rx_valid(rx_valid), .cnt_zero(cnt_zero));

  spi_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(active), .sel_low(sel_low),
    .drv_edge(drv_edge), .cnt_zero(cnt_zero), .tx_data(tx_data),
    .tx_load(tx_load), .tx_ready(tx_ready), .load_evt(load_evt),
    .so(so), .so_oe(so_oe));
endmodule

// File: rtl/spi_autodet_checker.sv
module spi_autodet_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n_s,
  input logic sck_s,
  input logic sel_start,
  input logic cap_edge,
  input logic drv_edge,
  input logic mode,
  input logic armed,
  input logic load_evt,
  input logic so,
  input logic so_oe,
  input logic rx_valid,
  input logic tx_load,
  input logic tx_ready
);
  // R1: mode does not change during a selection once latched
  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && $past(!cs_n_s) && !$past(sel_start)) |-> $stable(mode));

  // R3: selecting with SCK high gives no capture in the next cycle
  a_r3_no_first_high_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && sck_s) |=> !cap_edge);

  // R2: a capture only happens with SCK high
  a_r2_capture_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |-> (sck_s && armed));

  // R4: valid strobe lasts one cycle
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7: no byte is delivered from a deselected period
  a_r7_valid_selected: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(cs_n_s));

  // R6: output enable is low while deselected
  a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !so_oe);

  // R5: SO holds unless a falling edge or a load preceded
  a_r5_so_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(drv_edge) && !$past(load_evt)) |-> $stable(so));

  // R8: an accepted load drops ready
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_ready && !load_evt) |=> !tx_ready);
endmodule

bind spi_autodet_target spi_autodet_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s),
  .sel_start(sel_start), .cap_edge(cap_edge), .drv_edge(drv_edge),
  .mode(mode), .armed(armed), .load_evt(load_evt), .so(so), .so_oe(so_oe),
  .rx_valid(rx_valid), .tx_load(tx_load), .tx_ready(tx_ready));

// File: tb/spi_autodet_target_tb.sv
module spi_autodet_target_tb_top;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic       so, so_oe, rx_valid, tx_ready;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  logic       tx_load = 1'b0;

  int checks = 0, errors = 0;

  logic [7:0] feed_mem [0:63];
  int         feed_n = 0, feed_i = 0;
  logic [7:0] got_mem  [0:63];
  int         got_n = 0;

  always #5 clk = ~clk;

  spi_autodet_target dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_load(tx_load), .tx_ready(tx_ready));

  // feeder: offers queued bytes through the load handshake
  always @(negedge clk) begin
    if (feed_i < feed_n && tx_ready && !tx_load) begin
      tx_data <= feed_mem[feed_i % 64];
      tx_load <= 1'b1;
      feed_i  <= feed_i + 1;
    end else begin
      tx_load <= 1'b0;
    end
  end

  // monitor: records each delivered byte
  always @(negedge clk) begin
    if (rx_valid) begin
      got_mem[got_n % 64] <= rx_data;
      got_n <= got_n + 1;
    end
  end

  // {mode3, count, mosi[3], miso[3]}
  localparam logic [50:0] VECS [6] = '{
    {1'b0, 2'd1, 24'hA50000, 24'h3C0000},
    {1'b0, 2'd3, 24'h0180FF, 24'h5AC37E},
    {1'b1, 2'd2, 24'h960000, 24'hE10F00},
    {1'b1, 2'd3, 24'h7FFE55, 24'hAA8118},
    {1'b0, 2'd2, 24'hC33C00, 24'h00FF00},
    {1'b1, 2'd1, 24'h240000, 24'h990000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    feed_mem[feed_n % 64] = b;
    feed_n++;
  endtask

  task automatic run_xfer(input bit m3, input int n, input logic [23:0] mosi,
                          input logic [23:0] miso, input bit fed);
    int base;
    if (fed) for (int k = 0; k < n; k++) push(miso[23-8*k -: 8]);
    sck = m3;
    cyc(12);
    base = got_n;
    cs_n = 1'b0;
    cyc(12);
    if (m3) begin
      chk(so_oe == 1'b0, "R6/R1 mode3 oe before first fall", so_oe, 0);
      sck = 1'b0;
      cyc(HALF);
      chk(so_oe == 1'b1, "R6 mode3 oe after first fall", so_oe, 1);
    end else begin
      chk(so_oe == 1'b1, "R6/R1 mode0 oe at select", so_oe, 1);
    end
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        logic expb;
        expb = fed ? miso[23-8*k-(7-b)] : 1'b1;
        si = mosi[23-8*k-(7-b)];
        cyc(HALF);
        chk(so == expb, fed ? "R5 so bit" : "R9 underrun so bit", so, expb);
        sck = 1'b1;
        cyc(HALF);
        if (!(k == n-1 && b == 0) || !m3) begin
          sck = 1'b0;
          cyc(HALF);
        end
      end
    end
    cyc(6);
    chk(got_n - base == n, "R4 byte count", got_n - base, n);
    for (int k = 0; k < n; k++)
      chk(got_mem[(base+k) % 64] == mosi[23-8*k -: 8],
          m3 ? "R2/R3 mode3 rx byte" : "R2 mode0 rx byte",
          got_mem[(base+k) % 64], mosi[23-8*k -: 8]);
    cs_n = 1'b1;
    cyc(12);
    chk(so_oe == 1'b0, "R6 oe after deselect", so_oe, 0);
  endtask

  initial begin
    int base;
    cyc(4);
    chk(rx_valid == 1'b0, "R10 rx_valid reset", rx_valid, 0);
    chk(so_oe == 1'b0, "R10 so_oe reset", so_oe, 0);
    chk(tx_ready == 1'b1, "R10 tx_ready reset", tx_ready, 1);
    rst_n = 1'b1;
    cyc(4);

    // R8: load handshake
    push(8'h3C);
    cyc(4);
    chk(tx_ready == 1'b0, "R8 ready drops after load", tx_ready, 0);
    feed_n = feed_n - 1; feed_i = feed_i - 1;
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
    chk(tx_ready == 1'b1, "R8 ready after reset", tx_ready, 1);

    for (int v = 0; v < 6; v++)
      run_xfer(VECS[v][50], int'(VECS[v][49:48]), VECS[v][47:24], VECS[v][23:0], 1'b1);

    // R7: abort mid-byte, then a clean byte
    push(8'h5A);
    sck = 1'b0;
    cyc(12);
    base = got_n;
    cs_n = 1'b0;
    cyc(12);
    for (int b = 0; b < 4; b++) begin
      si = 1'b1; cyc(HALF); sck = 1'b1; cyc(HALF); sck = 1'b0; cyc(HALF);
    end
    cs_n = 1'b1;
    cyc(12);
    chk(got_n == base, "R7 no byte from aborted selection", got_n - base, 0);
    run_xfer(1'b0, 1, 24'h690000, 24'hB40000, 1'b1);

    // R9: mode 3 with nothing loaded
    run_xfer(1'b1, 2, 24'h81C300, 24'h000000, 1'b0);
    // R1: mode 0 right after mode 3
    run_xfer(1'b0, 1, 24'h0F0000, 24'hF00000, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule